// File: doc/BRIEF.md
# Binary Fractional Rate Multiplier

This block turns a free-running clock into single-cycle enable pulses whose average rate is a programmable fraction of the clock rate. An n-bit binary counter advances on every enabled clock. Decode logic splits the counter states into n pulse trains that never overlap. Each train fires half as often as the one before it. A rate word M selects which trains are ORed onto one merged output. That output therefore fires exactly M times in every aligned run of 2^n enabled clocks.

The pulses are enables for logic on the same clock, not derived clocks. The spacing between pulses is allowed to be uneven. Only the count per window is guaranteed. A typical use is pacing a datapath, or spreading M events across a fixed frame of clocks.

All outputs are registered. Each clock edge with enable high loads the output registers with the decode of the counter value held just before that edge, using the rate word sampled at that same edge. The same edge then increments the counter.

Top module: `rate_mult_top`

## Requirements
- R1: A clock edge with `rst` high clears the counter to 0 and drives `trains` and `merged` to 0 after that edge.
- R2: Each edge with `en` high and `rst` low increments the counter by one, wrapping from 2^n-1 to 0. The counter is seen through the train sequence.
- R3: Bit k-1 of `trains` (train Pk, k = 1..n) is 1 after an enabled edge exactly when, before that edge, the low k-1 counter bits were all 1 and counter bit k-1 was 0.
- R4: At most one bit of `trains` is 1 in any cycle.
- R5: An enabled edge taken while the counter is all ones leaves every bit of `trains` at 0.
- R6: Over an aligned window of 2^n enabled edges starting from counter 0, train Pk fires exactly 2^(n-k) times.
- R7: `merged` after an enabled edge equals the OR over k of (`rate[n-k]` AND Pk), using `rate` sampled at that edge. The MSB of `rate` weights P1.
- R8: Over an aligned window of 2^n enabled edges with constant `rate` = M, `merged` fires exactly M times, for every M from 0 to 2^n-1.
- R9: An edge with `en` low holds the counter and drives `trains` and `merged` to 0 after it.
- R10: A new `rate` value applies from the first edge at which it is sampled, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the counter and permits pulses |
| rate | input | CNT_W | Rate word M, pulses per 2^CNT_W enabled clocks |
| trains | output | CNT_W | Individual pulse trains; bit k-1 is train Pk |
| merged | output | 1 | OR of the trains selected by `rate` |

## Verification
On every cycle the assertions check these properties:
- the trains never overlap;
- the counter steps by one when enabled and holds when idle;
- both outputs go quiet after an idle edge;
- the all-ones state yields no train pulse;
- the merged output agrees with the trains and the rate word sampled at the previous edge.

The per-window totals can only be shown by the bench's scenarios. These are the exact count of M for every rate word, and the halving count of each train. The bench also covers reset, wrap-around, enable gaps and a rate change in mid-window.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int RM_MIN_W = 2;
  localparam int RM_MAX_W = 16;

  // Number of pulses train k (1-based) gives per 2^w clocks.
  function automatic int rm_train_hits(input int w, input int k);
    return 1 << (w - k);
  endfunction
endpackage

// File: rtl/rm_counter.sv
module rm_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rm_decoder.sv
module rm_decoder #(
  parameter int W = 4
) (
  input  logic [W-1:0] cnt,
  output logic [W-1:0] trains
);
  // Train k+1 fires when the low k bits are ones and bit k is zero.
  for (genvar k = 0; k < W; k++) begin : g_train
    if (k == 0) begin : g_first
      assign trains[0] = ~cnt[0];
    end else begin : g_rest
      assign trains[k] = (&cnt[k-1:0]) & ~cnt[k];
    end
  end
endmodule

// File: rtl/rm_merge.sv
module rm_merge #(
  parameter int W = 4
) (
  input  logic [W-1:0] trains,
  input  logic [W-1:0] rate,
  output logic         merged
);
  logic [W-1:0] weights;

  // The most significant rate bit selects the densest train.
  for (genvar k = 0; k < W; k++) begin : g_weight
    assign weights[k] = rate[W-1-k];
  end

  assign merged = |(trains & weights);
endmodule

// File: rtl/rate_mult_top.sv
module rate_mult_top #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] rate,
  output logic [CNT_W-1:0] trains,
  output logic             merged
);
  import rm_pkg::*;

  if (CNT_W < RM_MIN_W || CNT_W > RM_MAX_W) begin : g_bad_width
    $error("rate_mult_top: CNT_W out of range");
  end

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] trains_c;
  logic             merged_c;

  rm_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .cnt (cnt_q)
  );

  rm_decoder #(.W(CNT_W)) u_dec (
    .cnt    (cnt_q),
    .trains (trains_c)
  );

  rm_merge #(.W(CNT_W)) u_mrg (
    .trains (trains_c),
    .rate   (rate),
    .merged (merged_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trains <= '0;
      merged <= 1'b0;
    end else if (en) begin
      trains <= trains_c;
      merged <= merged_c;
    end else begin
      trains <= '0;
      merged <= 1'b0;
    end
  end
endmodule

// File: rtl/rm_checker.sv
module rm_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] rate,
  input logic [W-1:0] cnt,
  input logic [W-1:0] trains,
  input logic         merged
);
  logic [W-1:0] rev_rate;
  logic         cnt_full;

  always_comb begin
    for (int k = 0; k < W; k++) rev_rate[k] = rate[W-1-k];
  end
  assign cnt_full = &cnt;

  AST_TRAINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trains)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == $past(cnt) + W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (trains == '0 && !merged)); // R9
  AST_FULL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_full) |=> trains == '0); // R5
  AST_MERGE_MATCH: assert property (@(posedge clk) disable iff (rst)
    merged == |(trains & $past(rev_rate))); // R7
endmodule

bind rate_mult_top rm_checker #(.W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .rate   (rate),
  .cnt    (cnt_q),
  .trains (trains),
  .merged (merged)
);

// File: tb/tb_rate_mult_top.sv
`timescale 1ns/1ps
module tb_rate_mult_top;
  localparam int N = 4;
  localparam int WIN = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [N-1:0] rate = '0;
  logic [N-1:0] trains;
  logic         merged;

  integer n_cmp = 0;
  integer n_bad = 0;
  integer mcnt = 0;
  logic [N-1:0] exp_tr = '0;
  logic         exp_m = 1'b0;
  integer m_hits;
  integer tr_hits [N];
  logic   pre_full;

  rate_mult_top #(.CNT_W(N)) dut (
    .clk(clk), .rst(rst), .en(en), .rate(rate), .trains(trains), .merged(merged)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input integer act, input integer expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Drive inputs for one edge, predict its result, then compare afterwards.
  task automatic cycle(input logic r, input logic e, input logic [N-1:0] m);
    rst = r; en = e; rate = m;
    pre_full = (mcnt == WIN - 1);
    exp_tr = '0; exp_m = 1'b0;
    if (r) mcnt = 0;
    else if (e) begin
      for (int k = 1; k <= N; k++)
        if ((mcnt % (1 << k)) == (1 << (k - 1)) - 1) exp_tr[k-1] = 1'b1;
      for (int k = 1; k <= N; k++)
        if (m[N-k] && exp_tr[k-1]) exp_m = 1'b1;
      mcnt = (mcnt + 1) % WIN;
    end
    @(posedge clk);
    @(negedge clk);
    check("R3 R2 R9 trains", trains, exp_tr);
    check("R7 R10 merged", merged, exp_m);
    if ($countones(trains) > 1) check("R4 exclusive", $countones(trains), 1);
    if (e && !r && pre_full) check("R5 all-ones silent", trains, 0);
    if (merged) m_hits++;
    for (int k = 0; k < N; k++) if (trains[k]) tr_hits[k]++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, '1);
    check("R1 reset trains", trains, 0);
    check("R1 reset merged", merged, 0);

    // R8 and R6: every rate word over an aligned window
    for (int m = 0; m < WIN; m++) begin
      cycle(1'b1, 1'b0, N'(m));
      m_hits = 0;
      for (int k = 0; k < N; k++) tr_hits[k] = 0;
      for (int i = 0; i < WIN; i++) cycle(1'b0, 1'b1, N'(m));
      check("R8 window count", m_hits, m);
      for (int k = 1; k <= N; k++)
        check("R6 train count", tr_hits[k-1], rm_pkg::rm_train_hits(N, k));
    end

    // R2: run across several wraps
    cycle(1'b1, 1'b0, 4'd5);
    for (int i = 0; i < 3 * WIN + 3; i++) cycle(1'b0, 1'b1, 4'd5);

    // R9: enable gaps hold the counter and silence outputs
    for (int i = 0; i < 20; i++) cycle(1'b0, (i % 3) != 0, 4'd15);
    cycle(1'b0, 1'b0, 4'd15);
    check("R9 idle merged", merged, 0);
    check("R9 idle trains", trains, 0);

    // R10: rate changes mid-window
    for (int i = 0; i < 24; i++) cycle(1'b0, 1'b1, N'(i * 7));

    // R1: reset in the middle of activity
    cycle(1'b1, 1'b1, 4'd15);
    check("R1 mid reset trains", trains, 0);
    cycle(1'b0, 1'b1, 4'd8);
    check("R3 first after reset", trains, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule